// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Front End

This block is the digital side of a two-channel converter with a parallel data bus. A host drives a 12-bit word together with an active-low chip select and a channel-select bit. While chip select is low, the selected channel's input register tracks the bus. When chip select rises, that register keeps its last value. Each channel also has an active-low load strobe. While the strobe is low, the channel's code register keeps copying its input register. Two-stage updates are made by loading both input registers first and then pulsing both strobes together. Holding a strobe low instead gives single-buffered, pass-through updates.

All pin inputs except reset are brought onto the system clock through a synchroniser chain. Reset clears both register stages at once and is released synchronously. An active-low shutdown input does not stop register writes. It only withdraws the output enables. A small power state machine has three states:
- `PWR_ON`: outputs enabled and valid.
- `PWR_OFF`: outputs disabled.
- `PWR_WAKE`: outputs enabled but not yet valid while a recovery counter runs.

Its transitions are:
- ON→OFF when shutdown is seen low.
- OFF→WAKE when shutdown is seen high.
- WAKE→OFF when shutdown returns during recovery.
- WAKE→ON when the counter expires.

Each channel also runs a small observer with the states `IN_HOLD` and `IN_FOLLOW`. It moves HOLD→FOLLOW when a write to that channel begins and FOLLOW→HOLD when chip select rises.

Top module: `dual_dac_front`

## Requirements
- R1: The bus is `DATA_W` (12) bits with bit 11 the MSB. A code is the top `RES_W` bus bits. With `RES_W`=10, bus bits 1:0 are ignored and a code equals bus[11:2].
- R2: `ch_sel`=1 addresses channel A and `ch_sel`=0 addresses channel B. The address has no effect while `cs_n` is high.
- R3: While `cs_n` is low, the addressed input register follows the bus. After `cs_n` rises, it holds its last value, and later bus changes have no effect.
- R4: While a load strobe is low, its code output takes that channel's input register. While the strobe is high, the code output holds.
- R5: With both strobes low, both code outputs update from their own input registers.
- R6: A write made while a channel's strobe is held low reaches that channel's code output without any further strobe activity.
- R7: `rst_n` low asynchronously clears both input registers and both code outputs, and they stay zero while it is low. No register updates on the clock edge at which reset is released.
- R8: Shutdown (`sd_n` low) does not block writes to either register stage. Three clock edges after `sd_n` falls, `oe_a` and `oe_b` are 0, and they stay 0 while it is low.
- R9: On leaving shutdown, the code outputs show the latest code register contents, with no reload.
- R10: After `sd_n` rises, `oe_a`/`oe_b` return to 1 on the third edge. `valid_a`/`valid_b` stay 0 until edge 3+`RECOVER_CYC`. A shutdown during recovery returns to `PWR_OFF` and restarts the count. Out of reset, the state is `PWR_ON`.
- R11: With a strobe held low and `cs_n` low, a bus change appears on the code output on the fourth clock edge after it is applied, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (write enable) |
| ch_sel | input | 1 | Channel address: 1 = A, 0 = B |
| data | input | DATA_W | Parallel data bus, MSB first |
| ld_a_n | input | 1 | Active-low level load strobe, channel A |
| ld_b_n | input | 1 | Active-low level load strobe, channel B |
| sd_n | input | 1 | Active-low shutdown |
| code_a | output | RES_W | Channel A converter code |
| code_b | output | RES_W | Channel B converter code |
| oe_a | output | 1 | Channel A output driven |
| oe_b | output | 1 | Channel A/B output driven (channel B) |
| valid_a | output | 1 | Channel A output settled |
| valid_b | output | 1 | Channel B output settled |

## Verification
The hardest state to reach from the ports is a shutdown that returns while the recovery counter is part-way through `PWR_WAKE`. The bench releases shutdown, waits six edges so the counter is mid-count, and pulls shutdown low again. It then checks that a fresh release still needs the full recovery window. A reset that lands in the middle of a pass-through write is equally awkward. The bench holds chip select and a strobe low, drops reset between clock edges, and samples before the next edge to show the asynchronous clear. It then checks that the write still in progress is not taken on the release edge.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_OFF  = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_state_e;

    typedef enum logic {
        IN_HOLD   = 1'b0,
        IN_FOLLOW = 1'b1
    } in_state_e;

    localparam logic SEL_CH_A = 1'b1;
    localparam logic SEL_CH_B = 1'b0;

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
        end else begin
            st_q[0] <= d;
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_fe_pkg::*;
#(
    parameter int   DATA_W = 12,
    parameter int   RES_W  = 12,
    parameter logic CH_SEL = SEL_CH_A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lo,
    input  logic              sel,
    input  logic [DATA_W-1:0] bus,
    input  logic              ld_lo,
    output logic [RES_W-1:0]  in_q,
    output logic [RES_W-1:0]  dac_q
);
    localparam int TOP = DATA_W - 1;

    in_state_e in_st, in_nx;
    logic      wr_hit;

    assign wr_hit = cs_lo && (sel == CH_SEL);

    // observer of the write window: FOLLOW while addressed, HOLD after chip select rises
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_st <= IN_HOLD;
        else        in_st <= in_nx;
    end

    always_comb begin
        in_nx = in_st;
        unique case (in_st)
            IN_HOLD:   if (wr_hit)  in_nx = IN_FOLLOW;
            IN_FOLLOW: if (!wr_hit) in_nx = IN_HOLD;
            default:   in_nx = IN_HOLD;
        endcase
    end

    // first stage: transparent while addressed and selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      in_q <= '0;
        else if (wr_hit) in_q <= bus[TOP -: RES_W];
    end

    // second stage: transparent while load strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dac_q <= '0;
        else if (ld_lo) dac_q <= in_q;
    end

    p_hold_after_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_st == IN_FOLLOW && !cs_lo) |=> $stable(in_q));

    p_load_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (dac_q == $past(in_q)));

    p_strobe_high_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_lo |=> $stable(dac_q));

endmodule

// File: rtl/dac_pwr_fsm.sv
module dac_pwr_fsm
    import dac_fe_pkg::*;
#(
    parameter int RECOVER_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_lo,
    output logic drive_o,
    output logic valid_o
);
    localparam int            CW   = $clog2(RECOVER_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(RECOVER_CYC - 1);

    pwr_state_e    state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PWR_ON;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PWR_ON:   if (sd_lo) nxt = PWR_OFF;
            PWR_OFF:  if (!sd_lo) nxt = PWR_WAKE;
            PWR_WAKE: begin
                if (sd_lo)            nxt = PWR_OFF;
                else if (cnt == LAST) nxt = PWR_ON;
            end
            default:  nxt = PWR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (state != PWR_WAKE) cnt <= '0;
        else if (cnt != LAST)       cnt <= cnt + 1'b1;
    end

    always_comb begin
        drive_o = 1'b0;
        valid_o = 1'b0;
        unique case (state)
            PWR_ON:   begin drive_o = 1'b1; valid_o = 1'b1; end
            PWR_WAKE: begin drive_o = 1'b1; valid_o = 1'b0; end
            PWR_OFF:  begin drive_o = 1'b0; valid_o = 1'b0; end
            default:  begin drive_o = 1'b0; valid_o = 1'b0; end
        endcase
    end

    p_sd_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sd_lo |=> !drive_o);

    p_release_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PWR_OFF && !sd_lo) |=> (drive_o && !valid_o));

    p_valid_via_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(state) == PWR_WAKE));

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
    import dac_fe_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int RECOVER_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ch_sel,
    input  logic [DATA_W-1:0] data,
    input  logic              ld_a_n,
    input  logic              ld_b_n,
    input  logic              sd_n,
    output logic [RES_W-1:0]  code_a,
    output logic [RES_W-1:0]  code_b,
    output logic              oe_a,
    output logic              oe_b,
    output logic              valid_a,
    output logic              valid_b
);
    localparam int            NCH   = 2;
    localparam int            SW    = DATA_W + 5;
    localparam logic [SW-1:0] S_RST = {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, {DATA_W{1'b0}}};

    logic              rst_i;
    logic [SW-1:0]     raw_v, syn_v;
    logic              cs_s, sel_s, lda_s, ldb_s, sd_s;
    logic [DATA_W-1:0] bus_s;
    logic [NCH-1:0]    ld_lo;
    logic [RES_W-1:0]  in_r  [NCH];
    logic [RES_W-1:0]  dac_r [NCH];
    logic              drive, valid;

    dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk(clk), .arst_n(rst_n), .rst_n_o(rst_i)
    );

    assign raw_v = {cs_n, ch_sel, ld_a_n, ld_b_n, sd_n, data};

    dac_in_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(S_RST)) u_sync (
        .clk(clk), .rst_n(rst_i), .d(raw_v), .q(syn_v)
    );

    assign {cs_s, sel_s, lda_s, ldb_s, sd_s, bus_s} = syn_v;
    assign ld_lo = {~ldb_s, ~lda_s};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dac_chan #(
            .DATA_W(DATA_W),
            .RES_W (RES_W),
            .CH_SEL((c == 0) ? SEL_CH_A : SEL_CH_B)
        ) u_ch (
            .clk  (clk),
            .rst_n(rst_i),
            .cs_lo(~cs_s),
            .sel  (sel_s),
            .bus  (bus_s),
            .ld_lo(ld_lo[c]),
            .in_q (in_r[c]),
            .dac_q(dac_r[c])
        );
    end

    dac_pwr_fsm #(.RECOVER_CYC(RECOVER_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_i), .sd_lo(~sd_s),
        .drive_o(drive), .valid_o(valid)
    );

    assign code_a  = dac_r[0];
    assign code_b  = dac_r[1];
    assign oe_a    = drive;
    assign oe_b    = drive;
    assign valid_a = valid;
    assign valid_b = valid;

    p_reset_clears_r7: assert property (@(posedge clk)
        !rst_n |-> (code_a == '0 && code_b == '0));

    p_joint_load_r5: assert property (@(posedge clk) disable iff (!rst_i)
        (&ld_lo) |=> (code_a == $past(in_r[0]) && code_b == $past(in_r[1])));

    p_release_no_update_r7: assert property (@(posedge clk)
        (rst_n && !rst_i) |=> (in_r[0] == '0 && in_r[1] == '0));

endmodule

// File: tb/sim_dual_dac_front.sv
module sim_dual_dac_front;
    localparam int RC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        cs_n = 1'b1, ch_sel = 1'b0, ld_a_n = 1'b1, ld_b_n = 1'b1, sd_n = 1'b1;
    logic [11:0] data = '0;
    logic [11:0] code_a, code_b;
    logic [9:0]  n_a, n_b;
    logic        oe_a, oe_b, valid_a, valid_b;
    logic        n_oe_a, n_oe_b, n_va, n_vb;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dual_dac_front #(.RECOVER_CYC(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ch_sel(ch_sel), .data(data),
        .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .sd_n(sd_n),
        .code_a(code_a), .code_b(code_b), .oe_a(oe_a), .oe_b(oe_b),
        .valid_a(valid_a), .valid_b(valid_b)
    );

    dual_dac_front #(.RES_W(10), .RECOVER_CYC(RC)) u1 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ch_sel(ch_sel), .data(data),
        .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .sd_n(sd_n),
        .code_a(n_a), .code_b(n_b), .oe_a(n_oe_a), .oe_b(n_oe_b),
        .valid_a(n_va), .valid_b(n_vb)
    );

    // {cs_n, ch_sel, data, ld_a_n, ld_b_n, exp_a, exp_b}
    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 1'b1, 12'hA5C, 1'b1, 1'b1, 12'h000, 12'h000},
        {1'b1, 1'b1, 12'h123, 1'b1, 1'b1, 12'h000, 12'h000},
        {1'b1, 1'b0, 12'h123, 1'b0, 1'b1, 12'hA5C, 12'h000},
        {1'b0, 1'b0, 12'h3C7, 1'b1, 1'b1, 12'hA5C, 12'h000},
        {1'b1, 1'b0, 12'h3C7, 1'b1, 1'b0, 12'hA5C, 12'h3C7},
        {1'b0, 1'b1, 12'hFFF, 1'b1, 1'b1, 12'hA5C, 12'h3C7},
        {1'b0, 1'b0, 12'h001, 1'b1, 1'b1, 12'hA5C, 12'h3C7},
        {1'b1, 1'b0, 12'h001, 1'b0, 1'b0, 12'hFFF, 12'h001},
        {1'b0, 1'b1, 12'h800, 1'b0, 1'b0, 12'h800, 12'h001},
        {1'b0, 1'b0, 12'h7FF, 1'b0, 1'b0, 12'h800, 12'h7FF},
        {1'b1, 1'b0, 12'h000, 1'b1, 1'b1, 12'h800, 12'h7FF},
        {1'b1, 1'b1, 12'h555, 1'b0, 1'b0, 12'h800, 12'h7FF}
    };

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        step(3);
        chk("R7 reset code_a", code_a, 0);
        chk("R7 reset code_b", code_b, 0);
        chk("R10 reset oe", {oe_a, oe_b}, 2'b11);
        chk("R10 reset valid", {valid_a, valid_b}, 2'b11);
        rst_n = 1'b1;
        step(4);

        // table walk: R2 addressing, R3 hold, R4 load, R5 joint load, R6 pass-through
        for (int i = 0; i < NV; i++) begin
            {cs_n, ch_sel, data, ld_a_n, ld_b_n} = VEC[i][39:24];
            step(6);
            chk($sformatf("R2 R3 R4 R5 R6 vec %0d code_a", i), code_a, VEC[i][23:12]);
            chk($sformatf("R2 R3 R4 R5 R6 vec %0d code_b", i), code_b, VEC[i][11:0]);
            chk($sformatf("R1 10-bit vec %0d code_a", i), n_a, VEC[i][23:14]);
            chk($sformatf("R1 10-bit vec %0d code_b", i), n_b, VEC[i][11:2]);
        end

        // R11 latency of a pass-through write (strobes still low)
        cs_n = 1'b0; ch_sel = 1'b1; data = 12'h234;
        step(3);
        chk("R11 edge 3 still old", code_a, 12'h800);
        step(1);
        chk("R11 edge 4 new code", code_a, 12'h234);
        chk("R1 bus bits 1:0 dropped", n_a, 10'h08D);
        cs_n = 1'b1; ld_a_n = 1'b1; ld_b_n = 1'b1;
        step(4);

        // R8/R9/R10 shutdown with a write in between
        sd_n = 1'b0;
        step(2);
        chk("R8 oe before edge 3", oe_a, 1);
        step(1);
        chk("R8 oe off", {oe_a, oe_b}, 2'b00);
        chk("R10 valid off", {valid_a, valid_b}, 2'b00);
        cs_n = 1'b0; ch_sel = 1'b1; data = 12'h9AB; ld_a_n = 1'b0;
        step(6);
        chk("R8 write during shutdown", code_a, 12'h9AB);
        chk("R8 oe stays off", oe_b, 0);
        cs_n = 1'b1; ld_a_n = 1'b1;
        step(4);
        sd_n = 1'b1;
        step(3);
        chk("R10 oe back", {oe_a, oe_b}, 2'b11);
        chk("R10 valid still low", valid_a, 0);
        chk("R9 latest code kept", code_a, 12'h9AB);
        step(RC - 1);
        chk("R10 valid low at last wait edge", {valid_a, valid_b}, 2'b00);
        step(1);
        chk("R10 valid after recovery", {valid_a, valid_b}, 2'b11);

        // R10 shutdown during recovery restarts the count
        sd_n = 1'b0;
        step(6);
        sd_n = 1'b1;
        step(6);
        chk("R10 mid-wake valid low", valid_a, 0);
        sd_n = 1'b0;
        step(3);
        chk("R10 abort wake oe off", oe_a, 0);
        sd_n = 1'b1;
        step(3 + RC - 1);
        chk("R10 restarted count valid low", valid_b, 0);
        step(1);
        chk("R10 restarted count valid high", valid_b, 1);

        // R7 reset in the middle of a pass-through write to B
        cs_n = 1'b0; ch_sel = 1'b0; data = 12'h456; ld_b_n = 1'b0;
        step(2);
        rst_n = 1'b0;
        #1;
        chk("R7 async clear code_b", code_b, 0);
        chk("R7 async clear code_a", code_a, 0);
        step(3);
        chk("R7 held low code_b", code_b, 0);
        rst_n = 1'b1;
        step(1);
        chk("R7 no update at release", code_b, 0);
        step(7);
        chk("R7 write resumes after release", code_b, 12'h456);
        cs_n = 1'b1; ld_a_n = 1'b0;
        step(6);
        chk("R7 input register A cleared", code_a, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule